// File: doc/BRIEF.md
# Circle Outline Segment Generator

This block traces the outline of a two-dimensional circle as a chain of straight chords. Once armed, it takes a centre point, a radius and an angular step. It walks an angle index around a full turn held in a shared sine table, and scales each sampled sine and cosine by the radius. Each pair of neighbouring sampled points is emitted as one line segment, with a start point A and an end point B. A rasteriser downstream can draw each segment directly.

Each point is produced in two phases. The first phase fetches the trigonometric values for the current angle index into registers. The second phase computes the point and emits a segment. After the index passes a full turn, one more segment closes the outline back onto the first point, and a single-cycle completion pulse follows. The z component of both endpoints is always zero.

Top module: `circle_outline_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared. After that edge, `seg_valid`, `done` and all six coordinate outputs read zero.
- R2: A run starts only at a rising edge where the block is idle, `rst` is low, and both `arm` and `trigger` are high. Either control alone starts nothing.
- R3: The table has 64 signed 8-bit entries. Entry i equals 127·sin(2πi/64), rounded to the nearest integer with halves away from zero. The cosine of index i is the table entry at (i+16) mod 64.
- R4: The point for index i is x = cx + ((r·cos(i)) >>> 7) and y = cy + ((r·sin(i)) >>> 7). Here r is unsigned, the shift is arithmetic (floor), and the sums wrap modulo 2^16. `a_z` and `b_z` are always zero.
- R5: Segment k (counting from 1) of a run goes from the point at index (k−1)·s to the point at index k·s. Each segment's A equals the previous segment's B.
- R6: The effective step s is the low 6 bits of `step`, and a value of zero there means 64. A run emits exactly ceil(64/s) segments, so a step of 3 gives 22.
- R7: The last segment of a run starts at the last sampled point below index 64 and ends at the point for index 0.
- R8: Let E0 be the starting edge and K the segment count. Ordinary segment k appears in the cycle after edge E0+2k+2. The closing segment appears one edge after the last ordinary segment, which is after edge E0+2K+1. `seg_valid` is high for one cycle per segment.
- R9: `done` is high for exactly one cycle, directly after the cycle that carries the closing segment.
- R10: `arm`, `trigger`, centre, radius and step are ignored while a run is in progress. The segment stream of that run is unchanged.
- R11: A reset in the middle of a run aborts it. No further segment or `done` appears until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start qualifier, must be high with `trigger` |
| trigger | input | 1 | Start request, must be high with `arm` |
| center_x | input | 16 | Centre x coordinate, sampled at start |
| center_y | input | 16 | Centre y coordinate, sampled at start |
| radius | input | RAD_W (8) | Unsigned radius, sampled at start |
| step | input | STEP_W (16) | Angular step; low 6 bits used, sampled at start |
| seg_valid | output | 1 | One-cycle strobe marking a valid segment |
| a_x | output | 16 | Segment start x |
| a_y | output | 16 | Segment start y |
| a_z | output | 16 | Segment start z (zero) |
| b_x | output | 16 | Segment end x |
| b_y | output | 16 | Segment end y |
| b_z | output | 16 | Segment end z (zero) |
| done | output | 1 | One-cycle pulse after the closing segment |

## Verification
The bench checks each corner case against segment lists built from real-valued sine, independent of the design. A step whose low bits are zero must give a single degenerate closing chord. A design that took the step literally would never finish, or would emit 64 segments. A radius of 128 exposes every table entry exactly, so a wrong quadrant fold or a cosine offset error shows up as a mismatched coordinate. A centre near zero with the largest radius forces negative offsets and wrap-around, which catches a logical shift in place of an arithmetic one, and catches a missing sign extension. Start requests during a run, a lone `arm` or `trigger`, and a reset mid-run are all aimed at a controller that restarts or leaks segments. Each segment's arrival cycle is checked, as is the exact cycle of the completion pulse.

// File: rtl/circ_pkg.sv
package circ_pkg;

    localparam int PT_W    = 16;
    localparam int IDX_W   = 6;
    localparam int TBL_N   = 1 << IDX_W;
    localparam int QTR_N   = TBL_N / 4;
    localparam int AMP_W   = 8;
    localparam int FRAC_SH = 7;

    typedef logic signed [AMP_W-1:0] amp_t;

    typedef struct packed {
        logic [PT_W-1:0] x;
        logic [PT_W-1:0] y;
    } point_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_DRAW   = 2'd2
    } gen_state_e;

    // First quadrant of 127*sin, indices 0..16 of a 64-step turn
    function automatic amp_t quarter_amp(input logic [IDX_W-2:0] k);
        amp_t v;
        case (k)
            5'd0:  v = 8'sd0;
            5'd1:  v = 8'sd12;
            5'd2:  v = 8'sd25;
            5'd3:  v = 8'sd37;
            5'd4:  v = 8'sd49;
            5'd5:  v = 8'sd60;
            5'd6:  v = 8'sd71;
            5'd7:  v = 8'sd81;
            5'd8:  v = 8'sd90;
            5'd9:  v = 8'sd98;
            5'd10: v = 8'sd106;
            5'd11: v = 8'sd112;
            5'd12: v = 8'sd117;
            5'd13: v = 8'sd122;
            5'd14: v = 8'sd125;
            5'd15: v = 8'sd126;
            default: v = 8'sd127;
        endcase
        return v;
    endfunction

    // Full-turn sine by quadrant folding
    function automatic amp_t sine_at(input logic [IDX_W-1:0] i);
        logic [1:0]       quad;
        logic [IDX_W-2:0] j;
        logic [IDX_W-2:0] m;
        amp_t             v;
        quad = i[IDX_W-1 -: 2];
        j    = {1'b0, i[IDX_W-3:0]};
        m    = quad[0] ? ((IDX_W-1)'(QTR_N) - j) : j;
        v    = quarter_amp(m);
        return quad[1] ? -v : v;
    endfunction

endpackage

// File: rtl/circ_trig_rom.sv
module circ_trig_rom
    import circ_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output amp_t             sin_q,
    output amp_t             cos_q
);

    logic [IDX_W-1:0] cos_idx;

    always_comb cos_idx = idx + IDX_W'(QTR_N);

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_q <= '0;
            cos_q <= '0;
        end else if (en) begin
            sin_q <= sine_at(idx);
            cos_q <= sine_at(cos_idx);
        end
    end

endmodule

// File: rtl/circ_axis_scale.sv
module circ_axis_scale
    import circ_pkg::*;
#(
    parameter int RAD_W = 8
) (
    input  logic [PT_W-1:0]  centre,
    input  logic [RAD_W-1:0] radius,
    input  amp_t             amp,
    output logic [PT_W-1:0]  coord
);

    localparam int PW = RAD_W + 1 + AMP_W;
    localparam int WW = PW + PT_W;

    logic signed [PW-1:0] rad_s;
    logic signed [PW-1:0] amp_s;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] offs;
    logic signed [WW-1:0] offs_w;

    always_comb begin
        rad_s  = PW'({1'b0, radius});
        amp_s  = PW'(amp);
        prod   = rad_s * amp_s;
        offs   = prod >>> FRAC_SH;
        offs_w = WW'(offs);
        coord  = centre + offs_w[PT_W-1:0];
    end

endmodule

// File: rtl/circle_outline_gen.sv
module circle_outline_gen
    import circ_pkg::*;
#(
    parameter int RAD_W  = 8,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              trigger,
    input  logic [PT_W-1:0]   center_x,
    input  logic [PT_W-1:0]   center_y,
    input  logic [RAD_W-1:0]  radius,
    input  logic [STEP_W-1:0] step,
    output logic              seg_valid,
    output logic [PT_W-1:0]   a_x,
    output logic [PT_W-1:0]   a_y,
    output logic [PT_W-1:0]   a_z,
    output logic [PT_W-1:0]   b_x,
    output logic [PT_W-1:0]   b_y,
    output logic [PT_W-1:0]   b_z,
    output logic              done
);

    localparam int AXES = 2;

    gen_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   acc;
    logic [IDX_W:0]   step_q;
    logic [IDX_W:0]   step_eff;
    logic [IDX_W:0]   acc_n;
    logic [RAD_W-1:0] rad_q;
    point_t           cent_q;
    point_t           first_pt;
    point_t           prev_pt;
    point_t           cur_pt;
    logic             first_q;
    logic             closing_q;
    logic             last_q;
    amp_t             sin_q;
    amp_t             cos_q;
    logic             unused_step_hi;

    amp_t             axis_amp   [AXES];
    logic [PT_W-1:0]  axis_centre[AXES];
    logic [PT_W-1:0]  axis_coord [AXES];

    assign unused_step_hi = ^step[STEP_W-1:IDX_W];

    always_comb begin
        step_eff = (step[IDX_W-1:0] == '0) ? (IDX_W+1)'(TBL_N)
                                            : {1'b0, step[IDX_W-1:0]};
        acc_n    = acc + step_q;
    end

    circ_trig_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .en    (state == ST_LOOKUP),
        .idx   (idx),
        .sin_q (sin_q),
        .cos_q (cos_q)
    );

    assign axis_amp[0]    = cos_q;
    assign axis_amp[1]    = sin_q;
    assign axis_centre[0] = cent_q.x;
    assign axis_centre[1] = cent_q.y;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        circ_axis_scale #(.RAD_W(RAD_W)) u_scale (
            .centre (axis_centre[g]),
            .radius (rad_q),
            .amp    (axis_amp[g]),
            .coord  (axis_coord[g])
        );
    end

    assign cur_pt.x = axis_coord[0];
    assign cur_pt.y = axis_coord[1];

    assign a_z = '0;
    assign b_z = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= '0;
            acc       <= '0;
            step_q    <= '0;
            rad_q     <= '0;
            cent_q    <= '0;
            first_pt  <= '0;
            prev_pt   <= '0;
            first_q   <= 1'b0;
            closing_q <= 1'b0;
            last_q    <= 1'b0;
            seg_valid <= 1'b0;
            done      <= 1'b0;
            a_x       <= '0;
            a_y       <= '0;
            b_x       <= '0;
            b_y       <= '0;
        end else begin
            seg_valid <= 1'b0;
            done      <= last_q;
            last_q    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (arm && trigger) begin
                        cent_q.x  <= center_x;
                        cent_q.y  <= center_y;
                        rad_q     <= radius;
                        step_q    <= step_eff;
                        idx       <= '0;
                        acc       <= '0;
                        first_q   <= 1'b1;
                        closing_q <= 1'b0;
                        state     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    state <= ST_DRAW;
                end
                ST_DRAW: begin
                    if (closing_q) begin
                        seg_valid <= 1'b1;
                        a_x       <= prev_pt.x;
                        a_y       <= prev_pt.y;
                        b_x       <= first_pt.x;
                        b_y       <= first_pt.y;
                        last_q    <= 1'b1;
                        closing_q <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        if (first_q) begin
                            first_pt <= cur_pt;
                            first_q  <= 1'b0;
                        end else begin
                            seg_valid <= 1'b1;
                            a_x       <= prev_pt.x;
                            a_y       <= prev_pt.y;
                            b_x       <= cur_pt.x;
                            b_y       <= cur_pt.y;
                        end
                        prev_pt <= cur_pt;
                        if (acc_n[IDX_W]) begin
                            closing_q <= 1'b1;
                        end else begin
                            acc   <= acc_n;
                            idx   <= acc_n[IDX_W-1:0];
                            state <= ST_LOOKUP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/circle_outline_chk.sv
module circle_outline_chk
    import circ_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            seg_valid,
    input logic            done,
    input logic [PT_W-1:0] a_x,
    input logic [PT_W-1:0] a_y,
    input logic [PT_W-1:0] b_x,
    input logic [PT_W-1:0] b_y,
    input logic [1:0]      gen_state
);

    logic            have_prev;
    logic [PT_W-1:0] last_bx;
    logic [PT_W-1:0] last_by;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            have_prev <= 1'b0;
            last_bx   <= '0;
            last_by   <= '0;
        end else if (seg_valid) begin
            have_prev <= 1'b1;
            last_bx   <= b_x;
            last_by   <= b_y;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!seg_valid && !done)); // R1

    AST_SEG_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && have_prev) |-> (a_x == last_bx && a_y == last_by)); // R5

    AST_SEG_FROM_DRAW: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> ($past(gen_state) == 2'd2)); // R8

    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(seg_valid)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

endmodule

bind circle_outline_gen circle_outline_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .seg_valid (seg_valid),
    .done      (done),
    .a_x       (a_x),
    .a_y       (a_y),
    .b_x       (b_x),
    .b_y       (b_y),
    .gen_state (state)
);

// File: tb/circle_outline_gen_tb.sv
`timescale 1ns/1ps
module circle_outline_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        arm, trigger;
    logic [15:0] center_x, center_y;
    logic [7:0]  radius;
    logic [15:0] step;
    logic        seg_valid, done;
    logic [15:0] a_x, a_y, a_z, b_x, b_y, b_z;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    circle_outline_gen u_dut (
        .clk(clk), .rst(rst), .arm(arm), .trigger(trigger),
        .center_x(center_x), .center_y(center_y), .radius(radius), .step(step),
        .seg_valid(seg_valid), .a_x(a_x), .a_y(a_y), .a_z(a_z),
        .b_x(b_x), .b_y(b_y), .b_z(b_z), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3: rounded 127*sin over 64 steps
    function automatic int amp_of(input int i);
        real v;
        v = 127.0 * $sin(6.283185307179586 * i / 64.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    // R4: point coordinate for index i
    function automatic logic [15:0] ex_coord(input logic [15:0] c, input int r,
                                             input int i, input bit is_y);
        int a;
        int off;
        a   = is_y ? amp_of(i % 64) : amp_of((i + 16) % 64);
        off = (r * a) >>> 7;
        return 16'(int'(c) + off);
    endfunction

    task automatic outputs_zero(input string req);
        chk(seg_valid == 1'b0 && done == 1'b0, req, "strobes after reset",
            {seg_valid, done}, 0);
        chk(a_x == 0 && a_y == 0 && b_x == 0 && b_y == 0 && a_z == 0 && b_z == 0,
            req, "coords after reset", a_x | a_y | b_x | b_y, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        outputs_zero("R1");
        rst = 1'b0;
    endtask

    task automatic t_no_start;
        int seen;
        // R2: arm alone
        seen = 0;
        @(negedge clk); arm = 1'b1; trigger = 1'b0;
        @(negedge clk); arm = 1'b0;
        for (int m = 0; m < 14; m++) begin
            @(negedge clk);
            seen += int'(seg_valid) + int'(done);
        end
        chk(seen == 0, "R2", "activity with arm only", seen, 0);
        // R2: trigger alone
        seen = 0;
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
        for (int m = 0; m < 14; m++) begin
            @(negedge clk);
            seen += int'(seg_valid) + int'(done);
        end
        chk(seen == 0, "R2", "activity with trigger only", seen, 0);
    endtask

    task automatic t_circle(input logic [15:0] cx, input logic [15:0] cy,
                            input int r, input logic [15:0] st, input bit poke);
        int s, kseg, nseg, done_cnt, done_m, ia, ib;
        bit tim_ok, ev;
        string rq;
        s        = (st[5:0] == 0) ? 64 : int'(st[5:0]);
        kseg     = (64 + s - 1) / s;
        nseg     = 0;
        done_cnt = 0;
        done_m   = -1;
        tim_ok   = 1'b1;
        @(negedge clk);
        arm = 1'b1; trigger = 1'b1;
        center_x = cx; center_y = cy; radius = 8'(r); step = st;
        for (int m = 1; m <= 2 * kseg + 8; m++) begin
            @(negedge clk);
            if (m == 1) begin arm = 1'b0; trigger = 1'b0; end
            if (poke && m == 6) begin
                // R10: a start request while busy
                arm = 1'b1; trigger = 1'b1;
                center_x = 16'h7777; center_y = 16'h1111; radius = 8'h11; step = 16'd7;
            end
            if (poke && m == 7) begin arm = 1'b0; trigger = 1'b0; end
            ev = ((m >= 5) && (m <= 2 * kseg + 1) && (m % 2 == 1)) || (m == 2 * kseg + 2);
            if (seg_valid !== ev) tim_ok = 1'b0;
            if (seg_valid) begin
                nseg++;
                if (nseg <= kseg) begin
                    ia = (nseg - 1) * s;
                    ib = (nseg == kseg) ? 0 : nseg * s;
                    rq = (nseg == kseg) ? "R7" : (poke ? "R10" : "R5");
                    chk(a_x == ex_coord(cx, r, ia, 1'b0), rq, "a_x", a_x, ex_coord(cx, r, ia, 1'b0));
                    chk(a_y == ex_coord(cy, r, ia, 1'b1), rq, "a_y", a_y, ex_coord(cy, r, ia, 1'b1));
                    chk(b_x == ex_coord(cx, r, ib, 1'b0), rq, "b_x", b_x, ex_coord(cx, r, ib, 1'b0));
                    chk(b_y == ex_coord(cy, r, ib, 1'b1), rq, "b_y", b_y, ex_coord(cy, r, ib, 1'b1));
                    chk(a_z == 0 && b_z == 0, "R4", "z outputs", a_z | b_z, 0);
                end
            end
            if (done) begin
                done_cnt++;
                done_m = m;
            end
        end
        chk(tim_ok, "R8", "segment cycle pattern", int'(tim_ok), 1);
        chk(nseg == kseg, "R6", "segment count", nseg, kseg);
        chk(done_cnt == 1 && done_m == 2 * kseg + 3, "R9", "done cycle",
            done_m, 2 * kseg + 3);
    endtask

    task automatic t_reset_mid;
        int seen;
        @(negedge clk);
        arm = 1'b1; trigger = 1'b1;
        center_x = 16'd400; center_y = 16'd300; radius = 8'd50; step = 16'd1;
        @(negedge clk); arm = 1'b0; trigger = 1'b0;
        repeat (9) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        outputs_zero("R11");
        rst = 1'b0;
        seen = 0;
        for (int m = 0; m < 200; m++) begin
            @(negedge clk);
            seen += int'(seg_valid) + int'(done);
        end
        chk(seen == 0, "R11", "activity after mid-run reset", seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; arm = 1'b0; trigger = 1'b0;
        center_x = '0; center_y = '0; radius = '0; step = '0;
        t_reset();
        t_no_start();
        t_circle(16'd320, 16'd240, 100, 16'd3, 1'b0);      // R6 step 3
        t_circle(16'h1000, 16'h2000, 128, 16'd1, 1'b0);    // R3 every entry
        t_circle(16'h0005, 16'hFFF0, 255, 16'd16, 1'b0);   // R4 wrap
        t_circle(16'd50, 16'd60, 40, 16'h0040, 1'b0);      // R6 zero low bits
        t_circle(16'd77, 16'd88, 200, 16'h0043, 1'b0);     // R6 high bits ignored
        t_circle(16'd320, 16'd240, 90, 16'd3, 1'b1);       // R10
        t_circle(16'd10, 16'd20, 7, 16'd5, 1'b0);
        t_reset_mid();
        t_circle(16'd500, 16'd500, 60, 16'd8, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule